// File: doc/BRIEF.md
# Port Change Interrupt and Wake Controller

This block watches an input port for any difference against a reference value, and uses that difference as an interrupt source and as a way out of sleep. The reference is captured from the synchronized port value each time firmware reads the port. Firmware must therefore read the port once before it enables the change interrupt, so that the comparison starts from a known value. The change source is gathered with five other request lines: timer overflow, external interrupt pin, converter done, IR/PWM underflow and comparator change. Each source has a sticky pending flag and a per-source enable. A global enable gates the request to the core.

When the sleep instruction executes, the block enters sleep. It records whether the change interrupt was enabled at that moment. While asleep with that record set, any port difference raises a wake request. On the next clock edge the block leaves sleep and emits a one-cycle wake pulse. Alongside the pulse it tells the fetch logic what to do next. With the global enable off, the core continues with the instruction after the sleep instruction. With the global enable on, the core branches to the interrupt vector at 0x006.

Top module: `portchg_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `pend`, `irq`, `asleep`, `wake_req`, `wake_pulse` and `wake_vec` are 0, and the reference is 0.
- R2: `port_in` passes through two flops before it is compared. A pin change present at clock edge k sets `pend[1]` at edge k+2 and no earlier.
- R3: `rd_data` always shows the synchronized port value. A cycle with `port_rd` high loads that value into the reference at the clock edge.
- R4: A difference between the synchronized port and the reference on any one of the 8 pins sets `pend[1]`. Bit 1 is the change source.
- R5: Pending bit indices are 0 timer, 1 port change, 2 external pin, 3 converter done, 4 IR/PWM underflow and 5 comparator. A high `req_in[i]` sets `pend[i]` at the next edge, for i other than 1. `req_in[1]` has no effect.
- R6: Pending bits are sticky. A cycle with `pend_wr` high clears each bit whose `pend_wdata` bit is 0 and leaves the bits written 1 unchanged. An event in the same cycle as a clear leaves its bit set.
- R7: `irq` is high exactly when `gie` is high and some bit is set in both `pend` and `ien`.
- R8: `sleep_enter` while awake sets `asleep` at the next edge and records `ien[1]` as the wake arm.
- R9: `wake_req` is high only while asleep with the wake arm set and the synchronized port different from the reference. It is low whenever `asleep` is low.
- R10: At the edge after `wake_req` is high, `asleep` clears and `wake_pulse` is high for one cycle. `wake_vec` takes the `gie` value of that cycle and holds it until the next wake (1 = branch, 0 = continue in line). `redir_addr` shows 0x006 when `wake_vec` is 1 and 0 otherwise.
- R11: A port change during sleep without the wake arm still sets `pend[1]`, but raises no wake request and leaves `asleep` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 8 | Raw port pins |
| port_rd | input | 1 | Firmware port read strobe; loads the reference |
| rd_data | output | 8 | Synchronized port value |
| req_in | input | 6 | Event pulses from the other sources (bit 1 unused) |
| ien | input | 6 | Per-source enables |
| gie | input | 1 | Global interrupt enable |
| pend_wr | input | 1 | Pending-flag write strobe |
| pend_wdata | input | 6 | Write data; a 0 bit clears that flag |
| pend | output | 6 | Pending flags |
| irq | output | 1 | Interrupt request to the core |
| sleep_enter | input | 1 | Sleep instruction executed |
| asleep | output | 1 | Sleep state |
| wake_req | output | 1 | Wake request |
| wake_pulse | output | 1 | One-cycle wake event to the fetch logic |
| wake_vec | output | 1 | 1 = branch to vector, 0 = continue in line |
| redir_addr | output | 12 | Vector address when branching, else 0 |

## Verification
The bench builds the block with its defaults: an 8-pin port, six sources with the change source at index 1, and a 12-bit vector of 0x006. With these values every pin can be toggled one at a time, and every pending bit can be set and cleared individually. Both wake outcomes, continuing in line and branching to 0x006, are reached by running sleep twice with the global enable flipped between the runs. A third sleep with the change enable off shows that a change then sets the flag without waking the block.

// File: rtl/portchg_wake_ctrl.sv
module portchg_wake_ctrl #(
  parameter int PORT_W = 8,
  parameter int NSRC = 6,
  parameter int CHG_IDX = 1,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'h006
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  output logic [PORT_W-1:0] rd_data,
  input  logic [NSRC-1:0]   req_in,
  input  logic [NSRC-1:0]   ien,
  input  logic              gie,
  input  logic              pend_wr,
  input  logic [NSRC-1:0]   pend_wdata,
  output logic [NSRC-1:0]   pend,
  output logic              irq,
  input  logic              sleep_enter,
  output logic              asleep,
  output logic              wake_req,
  output logic              wake_pulse,
  output logic              wake_vec,
  output logic [ADDR_W-1:0] redir_addr
);

  logic [PORT_W-1:0] sync1, sync2, ref_q;
  logic [NSRC-1:0]   set_vec, keep_vec;
  logic              mism, arm_q;

  assign mism     = (sync2 != ref_q);
  assign rd_data  = sync2;
  assign keep_vec = pend_wr ? pend_wdata : '1;

  for (genvar i = 0; i < NSRC; i++) begin : g_set
    if (i == CHG_IDX) begin : g_chg
      assign set_vec[i] = mism;
    end else begin : g_ext
      assign set_vec[i] = req_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      ref_q <= '0;
      pend  <= '0;
    end else begin
      sync1 <= port_in;
      sync2 <= sync1;
      if (port_rd) ref_q <= sync2;
      pend <= (pend & keep_vec) | set_vec;
    end
  end

  assign irq      = gie & |(pend & ien);
  assign wake_req = asleep & arm_q & mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      arm_q      <= 1'b0;
      wake_pulse <= 1'b0;
      wake_vec   <= 1'b0;
    end else begin
      wake_pulse <= wake_req;
      if (wake_req) begin
        asleep   <= 1'b0;
        wake_vec <= gie;
      end else if (sleep_enter && !asleep) begin
        asleep <= 1'b1;
        arm_q  <= ien[CHG_IDX];
      end
    end
  end

  assign redir_addr = wake_vec ? VEC_ADDR : '0;

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> !wake_req);  // R9
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);  // R7
  AST_PULSE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(wake_req));  // R10
  AST_VEC_FROM_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (wake_vec == $past(gie)));  // R10
  AST_EXIT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> wake_pulse);  // R10
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend & $past(pend)) == $past(pend)));  // R6

endmodule

// File: tb/sim_portchg_wake_ctrl.sv
module sim_portchg_wake_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] port_in = '0;
  logic port_rd = 0, gie = 0, pend_wr = 0, sleep_enter = 0;
  logic [5:0] req_in = '0, ien = '0, pend_wdata = '0;
  logic [7:0] rd_data;
  logic [5:0] pend;
  logic irq, asleep, wake_req, wake_pulse, wake_vec;
  logic [11:0] redir_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  portchg_wake_ctrl u0 (.clk, .rst_n, .port_in, .port_rd, .rd_data, .req_in, .ien, .gie,
    .pend_wr, .pend_wdata, .pend, .irq, .sleep_enter, .asleep, .wake_req, .wake_pulse,
    .wake_vec, .redir_addr);

  always #4 clk = ~clk;

  // behavioural reference
  logic [7:0] m_q [$];
  logic [7:0] m_s2 = '0, m_ref = '0;
  logic [5:0] m_pend = '0;
  bit m_sleep = 0, m_arm = 0, m_wp = 0, m_wv = 0;
  initial begin m_q.push_back(8'h00); end

  function automatic bit m_mism(); return m_s2 != m_ref; endfunction
  function automatic bit m_wreq(); return m_sleep && m_arm && m_mism(); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_q.push_back(8'h00);
      m_s2 = '0; m_ref = '0; m_pend = '0;
      m_sleep = 0; m_arm = 0; m_wp = 0; m_wv = 0;
    end else begin
      bit wk;
      logic [5:0] ev;
      wk = m_wreq();
      ev = req_in;
      ev[1] = m_mism();
      if (pend_wr) m_pend = m_pend & pend_wdata;
      m_pend = m_pend | ev;
      if (port_rd) m_ref = m_s2;
      m_s2 = m_q.pop_front();
      m_q.push_back(port_in);
      m_wp = wk;
      if (wk) begin m_sleep = 0; m_wv = gie; end
      else if (sleep_enter && !m_sleep) begin m_sleep = 1; m_arm = ien[1]; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R3 rd_data", rd_data, m_s2);
      chk("R6 pend", pend, m_pend);
      chk("R7 irq", irq, gie && |(m_pend & ien));
      chk("R8 asleep", asleep, m_sleep);
      chk("R9 wake_req", wake_req, m_wreq());
      chk("R10 wake_pulse", wake_pulse, m_wp);
      chk("R10 wake_vec", wake_vec, m_wv);
      chk("R10 redir_addr", redir_addr, m_wv ? 12'h006 : 12'h000);
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic rd_clear();
    @(negedge clk) port_rd = 1;
    @(negedge clk) port_rd = 0; pend_wr = 1; pend_wdata = 6'b000000;
    @(negedge clk) pend_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    #1 chk("R1 pend in reset", pend, 0);
    chk("R1 asleep in reset", asleep, 0);
    rst_n = 1;
    cyc(1); #1;
    chk("R1 pend", pend, 0); chk("R1 irq", irq, 0); chk("R1 wake_pulse", wake_pulse, 0);
    chk("R1 wake_vec", wake_vec, 0); chk("R1 wake_req", wake_req, 0);

    port_in = 8'h5A; cyc(4); rd_clear(); cyc(2);
    chk("R3 rd_data after settle", rd_data, 8'h5A);
    chk("R3 reference taken: no pending change", pend[1], 0);

    for (int b = 0; b < 8; b++) begin
      port_in[b] = ~port_in[b];
      cyc(2); #1 chk("R2 not yet set after two edges", pend[1], 0);
      cyc(1); #1 chk("R4 change on single pin sets flag", pend[1], 1);
      rd_clear(); cyc(1);
      chk("R4 flag clear after read and clear", pend[1], 0);
    end

    for (int i = 0; i < 6; i++) begin
      req_in = 6'b1 << i;
      cyc(1); req_in = '0; #1;
      chk("R5 request sets its bit", pend[i], (i == 1) ? 0 : 1);
      pend_wr = 1; pend_wdata = '0; cyc(1); pend_wr = 0;
    end

    req_in = 6'b111101; cyc(1); req_in = '0;
    pend_wr = 1; pend_wdata = 6'b101010; cyc(1); pend_wr = 0; #1;
    chk("R6 write of 1 keeps, 0 clears", pend, 6'b101000);
    pend_wr = 1; pend_wdata = 6'b000000; req_in = 6'b000100; cyc(1);
    pend_wr = 0; req_in = '0; #1;
    chk("R6 set wins over clear", pend, 6'b000100);

    ien = 6'b000100; gie = 0; #1 chk("R7 no irq without gie", irq, 0);
    gie = 1; #1 chk("R7 irq with gie and enable", irq, 1);
    ien = 6'b000001; #1 chk("R7 no irq when enabled bit not pending", irq, 0);
    pend_wr = 1; pend_wdata = '0; cyc(1); pend_wr = 0;

    ien = 6'b000010; gie = 0;
    sleep_enter = 1; cyc(1); sleep_enter = 0; #1;
    chk("R8 asleep after sleep instruction", asleep, 1);
    cyc(3);
    port_in[3] = ~port_in[3];
    cyc(2); #1 chk("R9 wake request raised", wake_req, 1);
    cyc(1); #1 chk("R10 wake pulse", wake_pulse, 1);
    chk("R10 continue in line", wake_vec, 0);
    chk("R10 asleep cleared", asleep, 0);
    cyc(1); #1 chk("R10 pulse lasts one cycle", wake_pulse, 0);
    rd_clear();

    gie = 1;
    sleep_enter = 1; cyc(1); sleep_enter = 0; cyc(2);
    port_in[6] = ~port_in[6];
    cyc(3); #1 chk("R10 branch to vector", wake_vec, 1);
    chk("R10 vector address", redir_addr, 12'h006);
    gie = 0; rd_clear();

    ien = 6'b000000;
    sleep_enter = 1; cyc(1); sleep_enter = 0; cyc(2);
    port_in[0] = ~port_in[0];
    cyc(4); #1;
    chk("R11 flag set without arm", pend[1], 1);
    chk("R11 no wake request", wake_req, 0);
    chk("R11 still asleep", asleep, 1);

    cyc(1); rst_n = 0; cyc(2); #1;
    chk("R1 reset clears sleep", asleep, 0);
    chk("R1 reset clears pend", pend, 0);
    rst_n = 1; cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule